// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines from peripherals and presents them to a processor as one combined interrupt line. Each source is captured into a status bit. A synthesis-time mask sets every source as either level type or edge type. A level-type status bit follows its input. An edge-type status bit is set by a rising input and stays set until software acknowledges it. The status bits are gated by a per-source enable register to form the pending set. A priority encoder turns the pending set into a vector: the lowest-numbered pending source, or all ones when nothing is pending.

Software reaches the block over a plain single-cycle memory-mapped port. There is no back-pressure: every request is taken in the cycle it is presented. A read returns its data one cycle later, marked by a one-cycle valid strobe. Byte address bits [4:2] pick one of eight word registers. Any address with a nonzero bit above bit 4 falls outside the register file.

A two-bit control register holds two gates. Bit 1 allows inputs to be captured into status. Bit 0 allows the combined output line. The output can only be high when both bits are set.

Top module: `vic_core`

## Requirements
- R1: After reset, status, enable and control are zero, the vector register reads 0xFFFFFFFF and `irq_out` is low.
- R2: The pending register (offset 0x04) always reads status AND enable.
- R3: The vector register (offset 0x18) reads the index of the lowest-numbered set pending bit, or 0xFFFFFFFF when no pending bit is set.
- R4: `irq_out` is high exactly when control bits 1 and 0 are both set and at least one pending bit is set.
- R5: A write to the acknowledge register (offset 0x0C) clears every status bit whose written bit is 1 and leaves the other status bits alone.
- R6: A write to set-enable (offset 0x10) ORs the data into enable. A write to clear-enable (offset 0x14) clears the enable bits written as 1.
- R7: While control bit 1 is clear, input changes do not alter status and `irq_out` stays low.
- R8: With control bit 1 set, the status bit of a level-type source (mask bit 0) equals the input level sampled at the previous clock edge.
- R9: With control bit 1 set, a rising input on an edge-type source (mask bit 1) sets its status bit. The bit stays set after the input falls and until it is acknowledged. A rising input in the same cycle as the acknowledge of that bit leaves the bit set.
- R10: Reads of the write-only registers (offsets 0x0C, 0x10, 0x14) and of any address with a nonzero bit above bit 4 return zero. Writes to such addresses, and writes to pending and vector, change no register.
- R11: Writes to status (0x00), enable (0x08) and control (0x1C, data bits [1:0]) replace the whole register. Input capture in the same cycle takes precedence over a status write.
- R12: A read request returns its data on `bus_rdata` with `bus_rvalid` high in the next cycle. The data reflects the state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Interrupt request inputs, one per source |
| bus_req | input | 1 | Register access request, accepted in the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when `bus_rdata` holds a read result |
| irq_out | output | 1 | Combined interrupt line to the processor |

## Verification
The bench builds the block with 32 sources, an 8-bit address and an edge mask of 0xF0F0F0F0. Level-type and edge-type sources therefore alternate in groups of four, and random input words exercise both capture policies in the same cycle. The 8-bit address leaves 0x20 to 0xFF unmapped, so the random traffic also reaches the outside-the-file rule. Directed steps cover an acknowledge that coincides with a rising edge, and capture held off while a status write lands.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_PEND  = 3'd1,
    SEL_ENAB  = 3'd2,
    SEL_ACK   = 3'd3,
    SEL_SETEN = 3'd4,
    SEL_CLREN = 3'd5,
    SEL_VEC   = 3'd6,
    SEL_CTRL  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic cap_on;   // bit 1: capture inputs into status
    logic out_on;   // bit 0: allow the combined output
  } ctrl_t;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell #(
  parameter bit IS_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic irq_in,
  input  logic wr_load,
  input  logic load_val,
  input  logic ack_clr,
  output logic stat_o
);
  logic stat_q, prev_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (wr_load) stat_d = load_val;
    if (ack_clr) stat_d = 1'b0;
    if (cap_en) begin
      if (IS_EDGE) begin
        if (irq_in && !prev_q) stat_d = 1'b1;
      end else begin
        stat_d = irq_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      prev_q <= irq_in;
    end
  end

  assign stat_o = stat_q;

  p_hold_nocap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_load && !ack_clr) |=> $stable(stat_q));

  if (IS_EDGE) begin : g_edge_chk
    p_edge_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q && !ack_clr && !wr_load) |=> stat_q);
  end else begin : g_level_chk
    p_level_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (stat_q == $past(irq_in)));
  end
endmodule

// File: rtl/vic_lowest.sv
module vic_lowest #(
  parameter int N  = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int          NSRC      = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_0000,
  localparam int         IW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_out
);
  logic            hit, wr, rd;
  reg_sel_e        sel;
  logic [NSRC-1:0] stat, en_q, pend, wd;
  ctrl_t           ctrl_q;
  logic            found;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   vec_word, rd_mux;
  logic            unused_addr;

  assign unused_addr = ^bus_addr[1:0];
  assign hit = (bus_addr[ADDR_W-1:5] == '0);
  assign sel = reg_sel_e'(bus_addr[4:2]);
  assign wr  = bus_req && bus_we && hit;
  assign rd  = bus_req && !bus_we;
  assign wd  = bus_wdata[NSRC-1:0];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    vic_src_cell #(.IS_EDGE(EDGE_MASK[i])) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (ctrl_q.cap_on),
      .irq_in   (irq_src[i]),
      .wr_load  (wr && (sel == SEL_STAT)),
      .load_val (wd[i]),
      .ack_clr  (wr && (sel == SEL_ACK) && wd[i]),
      .stat_o   (stat[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_ENAB:  en_q   <= wd;
        SEL_SETEN: en_q   <= en_q | wd;
        SEL_CLREN: en_q   <= en_q & ~wd;
        SEL_CTRL:  ctrl_q <= ctrl_t'(bus_wdata[1:0]);
        default:   ;
      endcase
    end
  end

  assign pend = stat & en_q;

  vic_lowest #(.N(NSRC)) u_enc (
    .vec   (pend),
    .found (found),
    .idx   (idx)
  );

  assign vec_word = found ? DW'(idx) : '1;

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        SEL_STAT: rd_mux = DW'(stat);
        SEL_PEND: rd_mux = DW'(pend);
        SEL_ENAB: rd_mux = DW'(en_q);
        SEL_VEC:  rd_mux = vec_word;
        SEL_CTRL: rd_mux = DW'(ctrl_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign irq_out = ctrl_q.out_on && ctrl_q.cap_on && (pend != '0);

  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_ACK && !ctrl_q.cap_on) |=> ((stat & $past(wd)) == '0));
  p_set_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_SETEN) |=> ((en_q & $past(wd)) == $past(wd)));
  p_clr_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CLREN) |=> ((en_q & $past(wd)) == '0));
  p_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[idx] && ((pend & ((NSRC'(1) << idx) - NSRC'(1))) == '0)));
  p_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> (bus_rdata == '0));
endmodule

// File: tb/vic_core_test.sv
module vic_core_test;
  localparam logic [31:0] EMASK = 32'hF0F0_F0F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_stat, m_en, m_prev;
  logic [1:0]  m_ctrl;

  always #4 clk = ~clk;

  vic_core #(.NSRC(32), .ADDR_W(8), .EDGE_MASK(EMASK)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out)
  );

  // Reference model, updated from the requirements at each rising edge.
  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] s, e;
    logic [1:0]  c;
    if (!rst_n) begin
      m_stat <= '0; m_en <= '0; m_ctrl <= '0; m_prev <= '0;
    end else begin
      s = m_stat; e = m_en; c = m_ctrl;
      if (bus_req && bus_we && bus_addr[7:5] == 3'd0) begin
        case (bus_addr[4:2])
          3'd0: s = bus_wdata;
          3'd2: e = bus_wdata;
          3'd3: s = s & ~bus_wdata;
          3'd4: e = e | bus_wdata;
          3'd5: e = e & ~bus_wdata;
          3'd7: c = bus_wdata[1:0];
          default: ;
        endcase
      end
      if (m_ctrl[1]) begin
        for (int i = 0; i < 32; i++) begin
          if (EMASK[i]) begin
            if (irq_src[i] && !m_prev[i]) s[i] = 1'b1;
          end else begin
            s[i] = irq_src[i];
          end
        end
      end
      m_stat <= s; m_en <= e; m_ctrl <= c; m_prev <= irq_src;
    end
  end

  function automatic logic [31:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a[7:5] != 3'd0) return '0;
    case (a[4:2])
      3'd0: return m_stat;
      3'd1: return m_stat & m_en;
      3'd2: return m_en;
      3'd6: return lowest(m_stat & m_en);
      3'd7: return {30'd0, m_ctrl};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    if (a[7:5] != 3'd0) return "R10";
    case (a[4:2])
      3'd0: return "R11";
      3'd1: return "R2";
      3'd2: return "R6";
      3'd6: return "R3";
      3'd7: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Entered at a falling edge; returns at the next falling edge.
  task automatic step(input logic rq, input logic we, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] src, input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    irq_src = src; bus_req = rq; bus_we = we; bus_addr = a; bus_wdata = d;
    exp_rd = model_read(a);
    @(negedge clk);
    exp_irq = (m_ctrl == 2'b11) && ((m_stat & m_en) != 0);
    chk("R12", {31'd0, bus_rvalid}, {31'd0, rq && !we});
    if (rq && !we) chk(tag, bus_rdata, exp_rd);
    chk((m_ctrl[1] ? "R4" : "R7"), {31'd0, irq_out}, {31'd0, exp_irq});
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] src, input string tag);
    step(1'b1, 1'b0, a, 32'd0, src, tag);
  endtask

  task automatic wrt(input logic [7:0] a, input logic [31:0] d, input logic [31:0] src);
    step(1'b1, 1'b1, a, d, src, "R11");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] src;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, 0, "R1"); rd(8'h08, 0, "R1"); rd(8'h18, 0, "R1"); rd(8'h1C, 0, "R1");
    chk("R1", {31'd0, irq_out}, 32'd0);

    // Enable capture and output, enable bits 0 and 4 (R6, R11)
    wrt(8'h1C, 32'd3, 0);
    wrt(8'h10, 32'h11, 0);
    rd(8'h08, 0, "R6");

    // Level source 0 (R8, R2, R3, R4)
    step(0, 0, 0, 0, 32'h1, "R8");
    rd(8'h00, 32'h1, "R8");
    rd(8'h04, 32'h1, "R2");
    rd(8'h18, 32'h1, "R3");

    // Edge source 4 sticks after the input falls (R9)
    step(0, 0, 0, 0, 32'h11, "R9");
    step(0, 0, 0, 0, 32'h0, "R9");
    rd(8'h00, 0, "R9");
    rd(8'h18, 0, "R3");

    // Acknowledge clears it (R5)
    wrt(8'h0C, 32'h10, 0);
    rd(8'h00, 0, "R5");

    // Acknowledge in the same cycle as a new rising edge: bit stays set (R9)
    step(0, 0, 0, 0, 32'h0, "R9");
    wrt(8'h0C, 32'h10, 32'h10);
    rd(8'h00, 32'h10, "R9");

    // Clear-enable (R6)
    wrt(8'h14, 32'h10, 32'h10);
    rd(8'h08, 32'h10, "R6");
    rd(8'h04, 32'h10, "R2");

    // Capture off: status held, output low (R7)
    wrt(8'h10, 32'hFFFF_FFFF, 32'h10);
    wrt(8'h1C, 32'd1, 32'h10);
    step(0, 0, 0, 0, 32'h0000_FF0F, "R7");
    step(0, 0, 0, 0, 32'hFFFF_0000, "R7");
    rd(8'h00, 32'hFFFF_0000, "R7");

    // Status overwrite while capture off (R11)
    wrt(8'h00, 32'hDEAD_BEEF, 32'h0);
    rd(8'h00, 0, "R11");
    rd(8'h18, 0, "R3");

    // Capture on, output off: no interrupt (R4)
    wrt(8'h1C, 32'd2, 0);
    rd(8'h04, 0, "R2");

    // Unmapped and read-only writes ignored (R10)
    wrt(8'h20, 32'hFFFF_FFFF, 0);
    wrt(8'h04, 32'hFFFF_FFFF, 0);
    wrt(8'h18, 32'h0, 0);
    rd(8'h20, 0, "R10"); rd(8'hE4, 0, "R10"); rd(8'h0C, 0, "R10");
    rd(8'h08, 0, "R10"); rd(8'h00, 0, "R10");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int op;
      src = (($urandom % 4) == 0) ? $urandom : irq_src;
      a = (($urandom % 10) == 0) ? 8'($urandom) : {3'd0, 3'($urandom), 2'd0};
      d = $urandom;
      if (a == 8'h1C) d = (($urandom % 4) == 0) ? 32'($urandom % 4) : 32'd3;
      op = $urandom % 4;
      case (op)
        0: step(0, 0, 0, 0, src, "R4");
        1: step(1, 1, a, d, src, req_of(a));
        default: rd(a, src, req_of(a));
      endcase
    end

    step(0, 0, 0, 0, irq_src, "R4");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule